// File: doc/BRIEF.md
# Interrupt Controller Mode-Transition Unit

This unit holds the operating mode of a local interrupt controller and guards every change to it. There are three modes: disabled, legacy and extended. Software requests a mode by writing an enable bit and an extended bit. The unit checks the request against the current mode. It accepts the request or rejects it with a protection fault, and it decides which of the modelled controller registers keep their contents across the change. The modelled registers are a 32-bit extended ID, an 8-bit legacy ID, a logical destination register and the upper half of the interrupt command register.

Two further events act on the unit. A RESET event (the asynchronous `rst_ni` or a synchronous `reset_req_i` pulse) returns the unit to legacy mode and reloads everything from the hardware ID input. An INIT event keeps the current mode and the extended ID and reinitialises the rest. Leaving extended mode for legacy mode takes two writes, passing through disabled. Only the extended ID survives that path.

Top module: `irq_mode_ctrl`

## Requirements
- R1: On a RESET (`rst_ni` low, or `reset_req_i` high at a clock edge), `mode_o` becomes legacy, `ext_id_o` loads `hw_id_i`, `leg_id_o` loads `hw_id_i[7:0]`, and `ldr_o` and `icr_hi_o` clear to zero; `hw_id_i` is sampled only then. Mode codes on `mode_o` and on {`mode_en_i`,`mode_ext_i`} are 00 disabled, 10 legacy, 11 extended.
- R2: In extended mode, a request of 00 is accepted and moves the unit to disabled with all four registers unchanged; a request of 11 is accepted and changes nothing.
- R3: In extended mode, a request of 10 (extended to legacy) is rejected with a fault and leaves the mode and all registers unchanged.
- R4: In disabled mode, only requests 10 (to legacy) and 00 (no change) are accepted; a request of 11 faults.
- R5: The code 01 is rejected with a fault in every mode.
- R6: In legacy mode, requests 00, 10 and 11 are all accepted.
- R7: On the legacy-to-extended transition, `ldr_o` and `icr_hi_o` clear, `leg_id_o` discards any software-written value and returns to `ext_id_o[7:0]`, and `ext_id_o` is kept.
- R8: On the disabled-to-legacy transition, `ldr_o` and `icr_hi_o` clear and `leg_id_o` becomes `ext_id_o[7:0]`, so that only the extended ID survives the path extended, disabled, legacy.
- R9: INIT (`init_i`) keeps the current mode (disabled stays disabled, extended stays extended) and `ext_id_o`, clears `ldr_o` and `icr_hi_o`, and sets `leg_id_o` to `ext_id_o[7:0]`.
- R10: `fault_o` is high for exactly the one cycle after the edge that samples a rejected write, and is low otherwise.
- R11: Register writes (`reg_wr_i`) select by `reg_sel_i` as follows: 0 writes `leg_id_o` from `reg_wdata_i[7:0]` in legacy mode only; 1 writes `ldr_o` and 2 writes `icr_hi_o`, each in legacy or extended mode. Select 3, and any write while disabled, are ignored.
- R12: `reset_req_i` outranks `init_i`, which outranks `mode_wr_i`, and a lower-ranked event in the same cycle is dropped without a fault. `reg_wr_i` is dropped in any cycle in which any of these three is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (a RESET event) |
| hw_id_i | input | ID_W | Fixed hardware ID loaded on RESET |
| reset_req_i | input | 1 | Synchronous RESET event |
| init_i | input | 1 | INIT event |
| mode_wr_i | input | 1 | Mode-control register write strobe |
| mode_en_i | input | 1 | Requested enable bit |
| mode_ext_i | input | 1 | Requested extended bit |
| reg_wr_i | input | 1 | Controller register write strobe |
| reg_sel_i | input | 2 | Register select: 0 legacy ID, 1 logical destination, 2 command high, 3 none |
| reg_wdata_i | input | DAT_W | Register write data |
| mode_o | output | 2 | Current mode {enable, extended} |
| fault_o | output | 1 | Protection-fault pulse |
| ext_id_o | output | ID_W | Extended ID |
| leg_id_o | output | LID_W | Legacy ID |
| ldr_o | output | DAT_W | Logical destination register |
| icr_hi_o | output | DAT_W | Upper half of the interrupt command register |

## Verification
Mode requests and event handling can land in the same cycle as one another and as register writes. The bench raises INIT together with an illegal extended-to-legacy request. It raises a legal mode write together with a register write, and a synchronous reset together with the illegal 01 code. The scoreboard then expects the higher-ranked event's result alone: no fault, the register it would have written unchanged, and legacy mode with the freshly sampled hardware ID after the reset.

// File: rtl/irq_mode_pkg.sv
package irq_mode_pkg;
  typedef enum logic [1:0] {
    MODE_DIS = 2'b00,
    MODE_BAD = 2'b01,
    MODE_LEG = 2'b10,
    MODE_EXT = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    SEL_LID  = 2'd0,
    SEL_LDR  = 2'd1,
    SEL_ICRH = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  typedef struct packed {
    logic accept;
    logic wipe;
  } xfer_s;
endpackage

// File: rtl/irq_mode_rules.sv
module irq_mode_rules
  import irq_mode_pkg::*;
(
  input  mode_e       cur_i,
  input  logic [1:0]  req_i,
  output xfer_s       xfer_o
);
  logic acc;

  always_comb begin
    acc = 1'b0;
    case (cur_i)
      MODE_EXT: acc = (req_i == MODE_DIS) || (req_i == MODE_EXT);
      MODE_DIS: acc = (req_i == MODE_DIS) || (req_i == MODE_LEG);
      MODE_LEG: acc = (req_i != MODE_BAD);
      default:  acc = 1'b0;
    endcase
  end

  // entering extended from legacy, or legacy from disabled, drops state
  assign xfer_o.accept = acc;
  assign xfer_o.wipe   = acc && (((cur_i == MODE_LEG) && (req_i == MODE_EXT)) ||
                                 ((cur_i == MODE_DIS) && (req_i == MODE_LEG)));
endmodule

// File: rtl/irq_mode_fsm.sv
module irq_mode_fsm
  import irq_mode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reset_req_i,
  input  logic       wr_take_i,
  input  logic [1:0] req_i,
  input  xfer_s      xfer_i,
  output mode_e      mode_o,
  output logic       fault_o
);
  mode_e mode_q;
  logic  fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_LEG;
      fault_q <= 1'b0;
    end else begin
      fault_q <= wr_take_i && !xfer_i.accept;
      if (reset_req_i)                     mode_q <= MODE_LEG;
      else if (wr_take_i && xfer_i.accept) mode_q <= mode_e'(req_i);
    end
  end

  assign mode_o  = mode_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/irq_mode_regs.sv
module irq_mode_regs
  import irq_mode_pkg::*;
#(
  parameter int ID_W  = 32,
  parameter int LID_W = 8,
  parameter int DAT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ID_W-1:0]  hw_id_i,
  input  logic             do_reset_i,
  input  logic             do_init_i,
  input  logic             do_wipe_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [DAT_W-1:0] reg_wdata_i,
  input  mode_e            mode_i,
  output logic [ID_W-1:0]  ext_id_o,
  output logic [LID_W-1:0] leg_id_o,
  output logic [DAT_W-1:0] ldr_o,
  output logic [DAT_W-1:0] icr_hi_o
);
  localparam int LidCopy = (LID_W < ID_W) ? LID_W : ID_W;

  logic [ID_W-1:0]  ext_id_q;
  logic [LID_W-1:0] leg_id_q;
  logic [DAT_W-1:0] ldr_q, icr_q;
  logic [LID_W-1:0] lid_from_ext, lid_from_hw, lid_from_wd;
  logic             en_any, we_lid, we_ldr, we_icr, clr_all;

  // legacy ID derived from the low bits of a wider ID, zero-extended if narrower
  generate
    if (LID_W > ID_W) begin : g_lid_pad
      assign lid_from_ext = {{(LID_W-ID_W){1'b0}}, ext_id_q};
      assign lid_from_hw  = {{(LID_W-ID_W){1'b0}}, hw_id_i};
    end else begin : g_lid_cut
      assign lid_from_ext = ext_id_q[LidCopy-1:0];
      assign lid_from_hw  = hw_id_i[LidCopy-1:0];
    end
    if (LID_W > DAT_W) begin : g_wd_pad
      assign lid_from_wd = {{(LID_W-DAT_W){1'b0}}, reg_wdata_i};
    end else begin : g_wd_cut
      assign lid_from_wd = reg_wdata_i[LID_W-1:0];
    end
  endgenerate

  assign en_any  = (mode_i == MODE_LEG) || (mode_i == MODE_EXT);
  assign we_lid  = reg_we_i && (reg_sel_i == SEL_LID)  && (mode_i == MODE_LEG);
  assign we_ldr  = reg_we_i && (reg_sel_i == SEL_LDR)  && en_any;
  assign we_icr  = reg_we_i && (reg_sel_i == SEL_ICRH) && en_any;
  assign clr_all = do_init_i || do_wipe_i;

  // hw_id_i is a strap: stable while rst_ni is asserted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_id_q <= hw_id_i;
      leg_id_q <= lid_from_hw;
      ldr_q    <= '0;
      icr_q    <= '0;
    end else if (do_reset_i) begin
      ext_id_q <= hw_id_i;
      leg_id_q <= lid_from_hw;
      ldr_q    <= '0;
      icr_q    <= '0;
    end else if (clr_all) begin
      leg_id_q <= lid_from_ext;
      ldr_q    <= '0;
      icr_q    <= '0;
    end else begin
      if (we_lid) leg_id_q <= lid_from_wd;
      if (we_ldr) ldr_q    <= reg_wdata_i;
      if (we_icr) icr_q    <= reg_wdata_i;
    end
  end

  assign ext_id_o = ext_id_q;
  assign leg_id_o = leg_id_q;
  assign ldr_o    = ldr_q;
  assign icr_hi_o = icr_q;
endmodule

// File: rtl/irq_mode_ctrl.sv
module irq_mode_ctrl
  import irq_mode_pkg::*;
#(
  parameter int ID_W  = 32,
  parameter int LID_W = 8,
  parameter int DAT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ID_W-1:0]  hw_id_i,
  input  logic             reset_req_i,
  input  logic             init_i,
  input  logic             mode_wr_i,
  input  logic             mode_en_i,
  input  logic             mode_ext_i,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [DAT_W-1:0] reg_wdata_i,
  output logic [1:0]       mode_o,
  output logic             fault_o,
  output logic [ID_W-1:0]  ext_id_o,
  output logic [LID_W-1:0] leg_id_o,
  output logic [DAT_W-1:0] ldr_o,
  output logic [DAT_W-1:0] icr_hi_o
);
  mode_e      mode_q;
  xfer_s      xfer;
  logic [1:0] req;
  logic       do_init, wr_take, reg_we;

  assign req     = {mode_en_i, mode_ext_i};
  // precedence: reset > init > mode write > register write
  assign do_init = init_i && !reset_req_i;
  assign wr_take = mode_wr_i && !reset_req_i && !init_i;
  assign reg_we  = reg_wr_i && !reset_req_i && !init_i && !mode_wr_i;

  irq_mode_rules u_rules (
    .cur_i  (mode_q),
    .req_i  (req),
    .xfer_o (xfer)
  );

  irq_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reset_req_i (reset_req_i),
    .wr_take_i   (wr_take),
    .req_i       (req),
    .xfer_i      (xfer),
    .mode_o      (mode_q),
    .fault_o     (fault_o)
  );

  irq_mode_regs #(
    .ID_W  (ID_W),
    .LID_W (LID_W),
    .DAT_W (DAT_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hw_id_i     (hw_id_i),
    .do_reset_i  (reset_req_i),
    .do_init_i   (do_init),
    .do_wipe_i   (wr_take && xfer.wipe),
    .reg_we_i    (reg_we),
    .reg_sel_i   (reg_sel_i),
    .reg_wdata_i (reg_wdata_i),
    .mode_i      (mode_q),
    .ext_id_o    (ext_id_o),
    .leg_id_o    (leg_id_o),
    .ldr_o       (ldr_o),
    .icr_hi_o    (icr_hi_o)
  );

  assign mode_o = mode_q;
endmodule

// File: rtl/irq_mode_ctrl_chk.sv
module irq_mode_ctrl_chk #(
  parameter int ID_W  = 32,
  parameter int LID_W = 8,
  parameter int DAT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [ID_W-1:0]  hw_id_i,
  input logic             reset_req_i,
  input logic             init_i,
  input logic             mode_wr_i,
  input logic             mode_en_i,
  input logic             mode_ext_i,
  input logic             reg_wr_i,
  input logic [1:0]       mode_o,
  input logic             fault_o,
  input logic [ID_W-1:0]  ext_id_o,
  input logic [LID_W-1:0] leg_id_o,
  input logic [DAT_W-1:0] ldr_o,
  input logic [DAT_W-1:0] icr_hi_o
);
  logic take;
  assign take = mode_wr_i && !reset_req_i && !init_i;

  // R1
  reset_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_i |=> (mode_o == 2'b10) && (ext_id_o == $past(hw_id_i)) &&
                    (ldr_o == '0) && (icr_hi_o == '0));

  // R2
  ext_exit_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && mode_o == 2'b11 && {mode_en_i, mode_ext_i} == 2'b00)
      |=> (mode_o == 2'b00) && $stable(leg_id_o) && $stable(ext_id_o) && !fault_o);

  // R3
  ext_to_leg_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && mode_o == 2'b11 && {mode_en_i, mode_ext_i} == 2'b10)
      |=> fault_o && (mode_o == 2'b11));

  // R5
  bad_code_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && {mode_en_i, mode_ext_i} == 2'b01) |=> fault_o && $stable(mode_o));

  // R9
  init_keep_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i && !reset_req_i) |=> $stable(mode_o) && $stable(ext_id_o) &&
                                 (ldr_o == '0) && (icr_hi_o == '0) && !fault_o);

  // R10
  fault_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(take));

  // R12
  reg_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && take && mode_o == 2'b10 && {mode_en_i, mode_ext_i} == 2'b10)
      |=> $stable(ldr_o) && $stable(icr_hi_o) && $stable(leg_id_o));
endmodule

bind irq_mode_ctrl irq_mode_ctrl_chk #(
  .ID_W  (ID_W),
  .LID_W (LID_W),
  .DAT_W (DAT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hw_id_i     (hw_id_i),
  .reset_req_i (reset_req_i),
  .init_i      (init_i),
  .mode_wr_i   (mode_wr_i),
  .mode_en_i   (mode_en_i),
  .mode_ext_i  (mode_ext_i),
  .reg_wr_i    (reg_wr_i),
  .mode_o      (mode_o),
  .fault_o     (fault_o),
  .ext_id_o    (ext_id_o),
  .leg_id_o    (leg_id_o),
  .ldr_o       (ldr_o),
  .icr_hi_o    (icr_hi_o)
);

// File: tb/irq_mode_ctrl_tb.sv
module irq_mode_ctrl_tb;
  localparam int ID_W  = 32;
  localparam int LID_W = 8;
  localparam int DAT_W = 32;

  typedef struct {
    logic [1:0]       mode;
    logic             fault;
    logic [ID_W-1:0]  eid;
    logic [LID_W-1:0] lid;
    logic [DAT_W-1:0] ldr;
    logic [DAT_W-1:0] icr;
    string            tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ID_W-1:0] hw_id = 32'hA5C3_1E42;
  logic rreq = 0, ini = 0, mw = 0, en = 0, ex = 0, rw = 0;
  logic [1:0] sel = 0;
  logic [DAT_W-1:0] wd = 0;
  logic [1:0] mode;
  logic fault;
  logic [ID_W-1:0] eid;
  logic [LID_W-1:0] lid;
  logic [DAT_W-1:0] ldr, icr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  exp_t q[$];

  // bench model state
  logic [1:0] m_mode;
  logic [ID_W-1:0] m_eid;
  logic [LID_W-1:0] m_lid;
  logic [DAT_W-1:0] m_ldr, m_icr;

  always #2.5 clk = ~clk;

  irq_mode_ctrl #(.ID_W(ID_W), .LID_W(LID_W), .DAT_W(DAT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hw_id_i(hw_id), .reset_req_i(rreq),
    .init_i(ini), .mode_wr_i(mw), .mode_en_i(en), .mode_ext_i(ex),
    .reg_wr_i(rw), .reg_sel_i(sel), .reg_wdata_i(wd),
    .mode_o(mode), .fault_o(fault), .ext_id_o(eid), .leg_id_o(lid),
    .ldr_o(ldr), .icr_hi_o(icr)
  );

  function automatic bit legal(input logic [1:0] cur, input logic [1:0] r);
    if (r == 2'b01) return 0;
    if (cur == 2'b11) return (r == 2'b00) || (r == 2'b11);
    if (cur == 2'b00) return (r == 2'b00) || (r == 2'b10);
    return 1;
  endfunction

  task automatic compare(input exp_t e);
    n_chk++;
    if (mode !== e.mode || fault !== e.fault || eid !== e.eid ||
        lid !== e.lid || ldr !== e.ldr || icr !== e.icr) begin
      n_fail++;
      $display("FAIL %s: got mode=%b fault=%b eid=%h lid=%h ldr=%h icr=%h exp mode=%b fault=%b eid=%h lid=%h ldr=%h icr=%h",
               e.tag, mode, fault, eid, lid, ldr, icr,
               e.mode, e.fault, e.eid, e.lid, e.ldr, e.icr);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) compare(q.pop_front());
  end

  // driver: apply one cycle of stimulus, model the result, queue it
  task automatic op(input logic a_rr, input logic a_in, input logic a_mw,
                    input logic [1:0] a_rq, input logic a_rw,
                    input logic [1:0] a_sel, input logic [DAT_W-1:0] a_wd,
                    input string tag);
    exp_t e;
    logic f;
    @(negedge clk);
    rreq = a_rr; ini = a_in; mw = a_mw; {en, ex} = a_rq;
    rw = a_rw; sel = a_sel; wd = a_wd;
    @(posedge clk);
    f = 0;
    if (a_rr) begin
      m_mode = 2'b10; m_eid = hw_id; m_lid = hw_id[LID_W-1:0]; m_ldr = '0; m_icr = '0;
    end else if (a_in) begin
      m_lid = m_eid[LID_W-1:0]; m_ldr = '0; m_icr = '0;
    end else if (a_mw) begin
      if (!legal(m_mode, a_rq)) f = 1;
      else begin
        if ((m_mode == 2'b10 && a_rq == 2'b11) || (m_mode == 2'b00 && a_rq == 2'b10)) begin
          m_lid = m_eid[LID_W-1:0]; m_ldr = '0; m_icr = '0;
        end
        m_mode = a_rq;
      end
    end else if (a_rw) begin
      if (a_sel == 2'd0 && m_mode == 2'b10) m_lid = a_wd[LID_W-1:0];
      if (a_sel == 2'd1 && m_mode != 2'b00) m_ldr = a_wd;
      if (a_sel == 2'd2 && m_mode != 2'b00) m_icr = a_wd;
    end
    e.mode = m_mode; e.fault = f; e.eid = m_eid; e.lid = m_lid;
    e.ldr = m_ldr; e.icr = m_icr; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic mwr(input logic [1:0] r, input string tag);
    op(0, 0, 1, r, 0, 2'd0, '0, tag);
  endtask
  task automatic rwr(input logic [1:0] s, input logic [DAT_W-1:0] d, input string tag);
    op(0, 0, 0, 2'b00, 1, s, d, tag);
  endtask
  task automatic idle(input string tag);
    op(0, 0, 0, 2'b00, 0, 2'd0, '0, tag);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang, exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    m_mode = 2'b10; m_eid = hw_id; m_lid = hw_id[LID_W-1:0]; m_ldr = '0; m_icr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset state");
    hw_id = 32'h0000_0077;            // later changes must not reach ext_id until RESET
    rwr(2'd0, 32'h0000_005A, "R11 legacy id write");
    rwr(2'd1, 32'h1111_0000, "R11 ldr write");
    rwr(2'd2, 32'h2200_0000, "R11 icr_hi write");
    rwr(2'd3, 32'hDEAD_BEEF, "R11 select 3 ignored");
    mwr(2'b11, "R7 legacy to extended");
    rwr(2'd0, 32'h0000_0099, "R11 legacy id write ignored in extended");
    rwr(2'd1, 32'h0000_0033, "R11 ldr write in extended");
    mwr(2'b10, "R3 extended to legacy faults");
    idle("R10 fault pulse ends");
    mwr(2'b01, "R5 code 01 faults in extended");
    mwr(2'b11, "R2 same-mode write in extended");
    rwr(2'd2, 32'h0000_0044, "R11 icr_hi write in extended");
    op(0, 1, 0, 2'b00, 0, 2'd0, '0, "R9 init in extended");
    rwr(2'd2, 32'h0000_0055, "R11 icr_hi write after init");
    rwr(2'd1, 32'h0000_0066, "R11 ldr write after init");
    mwr(2'b00, "R2 extended to disabled keeps state");
    rwr(2'd1, 32'h0000_0088, "R11 write ignored while disabled");
    mwr(2'b11, "R4 disabled to extended faults");
    mwr(2'b01, "R5 code 01 faults in disabled");
    mwr(2'b00, "R4 same-mode write in disabled");
    op(0, 1, 0, 2'b00, 0, 2'd0, '0, "R9 init keeps disabled");
    mwr(2'b10, "R8 disabled to legacy");
    rwr(2'd0, 32'h0000_0012, "R11 legacy id write");
    rwr(2'd1, 32'h0000_0013, "R11 ldr write");
    mwr(2'b01, "R5 code 01 faults in legacy");
    mwr(2'b10, "R6 same-mode write in legacy");
    mwr(2'b00, "R6 legacy to disabled");
    mwr(2'b10, "R8 back to legacy");
    rwr(2'd1, 32'h0000_0014, "R11 ldr write");
    op(0, 0, 1, 2'b10, 1, 2'd1, 32'h0000_0015, "R12 reg write dropped with mode write");
    mwr(2'b11, "R6 legacy to extended");
    op(0, 1, 1, 2'b10, 0, 2'd0, '0, "R12 init outranks illegal write");
    op(1, 0, 1, 2'b01, 0, 2'd0, '0, "R12 R1 reset request outranks write");
    op(1, 1, 0, 2'b00, 1, 2'd1, 32'h0000_0016, "R12 reset outranks init and reg write");
    idle("R10 no fault after reset");
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule